// File: doc/BRIEF.md
# Programmable priority interrupt arbiter

This block decides which interrupt the CPU takes next. Eight maskable sources (codes 0 to 7), a non-maskable request (code 8) and a software trap (code 9) each set a pending flag with a one-cycle request pulse. Each cycle the arbiter picks the most urgent eligible pending flag. If that flag outranks the handler now running, the arbiter raises `irq` and shows the winner's code and vector. The CPU pulses `ack` to take the interrupt and `ret` when the handler is done. Handlers nest. An in-service stack remembers the level of every interrupted handler, and each return restores the previous level.

The urgency of the eight maskable sources comes from a 24-bit map of eight 3-bit slots. Slot 0 is the most urgent level and slot 7 the least. Each slot holds the code of the source assigned to that level. The trap outranks everything. The non-maskable request ranks below the trap and above every mapped source. Software can drop the pending request of a maskable source with a clear command, unless that source is being serviced.

Top module: `intc_arbiter`

## Requirements
- R1: After a synchronous reset, `irq` and `in_service` are low and all eight mask bits are 0. The map holds code s in slot s, with slot s in bits [3s+2:3s].
- R2: A request pulse sets the source's pending flag. While the source's mask bit (bit c of the mask for code c) is 0, the flag is held but never presented. It is presented once the bit is written to 1.
- R3: Among eligible maskable sources, the one in the lowest-numbered slot wins, and `irq_code` shows its code 0 to 7.
- R4: If a code appears in several slots, the lowest-numbered of those slots sets its level. A code that is in no slot is never presented.
- R5: A pending trap is always presented first, with code 9. A pending non-maskable request is presented with code 8 ahead of every maskable source. Mask bits affect neither.
- R6: With `glob_en` low, maskable sources and the non-maskable request are not presented. The trap still is.
- R7: When `irq` is high, `ack` (without `ret`) clears the winner's pending flag and makes it the handler in service. From the next cycle `in_service` is high.
- R8: While a handler runs, `irq` rises only for a source whose level is strictly more urgent than the running one. That source then nests on `ack`.
- R9: `ret` ends the innermost handler and restores the level of the handler it interrupted. After the last return `in_service` is low.
- R10: While the trap handler is in service, `irq` stays low.
- R11: A clear command with a 3-bit code drops that source's pending request. It has no effect while that source is in service anywhere in the nesting.
- R12: A map write is taken only when `glob_en` is low and no handler is in service. At other times it is ignored.
- R13: The vector is 3 + 2c for maskable code c, 29 for code 8 and 31 for code 9. Code and vector read 0 while `irq` is low.
- R14: A request pulse in the same cycle as an acknowledge or clear of that source leaves the source pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 8 | Request pulses, bit c for source code c |
| nmi_req | input | 1 | Non-maskable request pulse |
| trap_req | input | 1 | Software trap request pulse |
| glob_en | input | 1 | Global enable for maskable and non-maskable sources |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 8 | New mask, 1 enables a source |
| prio_we | input | 1 | Priority map write strobe |
| prio_wdata | input | 24 | New map, slot s in bits [3s+2:3s] |
| clr_valid | input | 1 | Pending clear command strobe |
| clr_code | input | 3 | Source code to clear |
| ack | input | 1 | CPU takes the presented interrupt |
| ret | input | 1 | CPU ends the innermost handler |
| irq | output | 1 | Interrupt request to the CPU |
| irq_code | output | 4 | Winning source code |
| irq_vec | output | 8 | Winning handler vector |
| in_service | output | 1 | At least one handler is active |

## Verification
The arbiter is driven with single and simultaneous pulses under the default map, a reversed map and a map with duplicate and missing codes. This separates ordering by slot from ordering by code, and shows the lowest-slot rule. Requests that arrive while handlers of lower, equal and higher urgency run tell strict preemption apart from mere pending. Returns from two-deep nesting show that the earlier level is restored. Clears, map writes and mask changes are each issued both in their allowed state and in their blocked state. Requests are also made to coincide with an acknowledge or a clear of the same source, which checks the order in which set and clear are applied.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int NSRC      = 8;
    localparam int CODE_W    = $clog2(NSRC);
    localparam int NID       = NSRC + 2;
    localparam int ID_W      = $clog2(NID);
    localparam int NMI_ID    = NSRC;
    localparam int TRAP_ID   = NSRC + 1;
    localparam int RANK_W    = $clog2(NID + 1);
    localparam int RANK_NONE = NID;
    localparam int MAP_W     = NSRC * CODE_W;
    localparam int DEPTH_W   = $clog2(NID + 1);

    typedef logic [ID_W-1:0]   id_t;
    typedef logic [RANK_W-1:0] rank_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic  valid;
        id_t   id;
        rank_t rank;
    } cand_t;

    typedef struct packed {
        id_t   id;
        rank_t rank;
    } svc_ent_t;

    function automatic logic [MAP_W-1:0] default_map();
        logic [MAP_W-1:0] m;
        m = '0;
        for (int s = 0; s < NSRC; s++) begin
            m[s*CODE_W +: CODE_W] = code_t'(s);
        end
        return m;
    endfunction

    function automatic logic [NID-1:0] id_onehot(id_t id);
        return NID'(1) << id;
    endfunction
endpackage

// File: rtl/intc_prio_map.sv
module intc_prio_map
    import intc_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [MAP_W-1:0]             wdata,
    output logic [MAP_W-1:0]             map_q,
    output logic [NSRC-1:0][CODE_W-1:0]  lvl_o,
    output logic [NSRC-1:0]              lvl_ok_o
);
    always_ff @(posedge clk) begin
        if (rst)        map_q <= default_map();
        else if (wr_en) map_q <= wdata;
    end

    // Descending scan: the lowest slot holding a code is the last match.
    always_comb begin
        for (int c = 0; c < NSRC; c++) begin
            lvl_o[c]    = '0;
            lvl_ok_o[c] = 1'b0;
            for (int s = NSRC - 1; s >= 0; s--) begin
                if (map_q[s*CODE_W +: CODE_W] == code_t'(c)) begin
                    lvl_o[c]    = code_t'(s);
                    lvl_ok_o[c] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/intc_pending.sv
module intc_pending
    import intc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NID-1:0]  set_i,
    input  logic [NID-1:0]  clr_i,
    input  logic            mask_we,
    input  logic [NSRC-1:0] mask_wdata,
    output logic [NID-1:0]  pend_o,
    output logic [NSRC-1:0] mask_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_o <= '0;
            mask_o <= '0;
        end else begin
            // New requests win over clears in the same cycle.
            pend_o <= (pend_o & ~clr_i) | set_i;
            if (mask_we) mask_o <= mask_wdata;
        end
    end
endmodule

// File: rtl/intc_select.sv
module intc_select
    import intc_pkg::*;
(
    input  logic [NID-1:0]              pend,
    input  logic [NSRC-1:0]             mask,
    input  logic                        glob_en,
    input  logic [NSRC-1:0][CODE_W-1:0] lvl,
    input  logic [NSRC-1:0]             lvl_ok,
    output cand_t                       win_o
);
    logic [NSRC-1:0] elig;
    rank_t           src_rank [NSRC];

    generate
        for (genvar c = 0; c < NSRC; c++) begin : g_src
            assign elig[c]     = pend[c] & mask[c] & glob_en & lvl_ok[c];
            assign src_rank[c] = rank_t'(lvl[c]) + rank_t'(2);
        end
    endgenerate

    always_comb begin
        win_o.valid = 1'b0;
        win_o.id    = '0;
        win_o.rank  = rank_t'(RANK_NONE);
        for (int c = 0; c < NSRC; c++) begin
            if (elig[c] && (src_rank[c] < win_o.rank)) begin
                win_o.valid = 1'b1;
                win_o.id    = id_t'(c);
                win_o.rank  = src_rank[c];
            end
        end
        if (pend[NMI_ID] && glob_en) begin
            win_o.valid = 1'b1;
            win_o.id    = id_t'(NMI_ID);
            win_o.rank  = rank_t'(1);
        end
        if (pend[TRAP_ID]) begin
            win_o.valid = 1'b1;
            win_o.id    = id_t'(TRAP_ID);
            win_o.rank  = rank_t'(0);
        end
    end
endmodule

// File: rtl/intc_svc_stack.sv
module intc_svc_stack
    import intc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               push,
    input  logic               pop,
    input  svc_ent_t           push_ent,
    output svc_ent_t           top_o,
    output logic [DEPTH_W-1:0] cnt_o,
    output logic [NID-1:0]     svc_mask_o
);
    svc_ent_t stk_q [NID];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o <= '0;
            for (int i = 0; i < NID; i++) stk_q[i] <= '0;
        end else if (pop && cnt_o != '0) begin
            cnt_o <= cnt_o - 1'b1;
        end else if (push && cnt_o < DEPTH_W'(NID)) begin
            stk_q[cnt_o] <= push_ent;
            cnt_o        <= cnt_o + 1'b1;
        end
    end

    always_comb begin
        if (cnt_o == '0) begin
            top_o.id   = '0;
            top_o.rank = rank_t'(RANK_NONE);
        end else begin
            top_o = stk_q[cnt_o - 1'b1];
        end
    end

    always_comb begin
        svc_mask_o = '0;
        for (int i = 0; i < NID; i++) begin
            if (DEPTH_W'(i) < cnt_o) svc_mask_o = svc_mask_o | id_onehot(stk_q[i].id);
        end
    end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import intc_pkg::*;
#(
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 3,
    parameter int VEC_STEP = 2,
    parameter int NMI_VEC  = 29,
    parameter int TRAP_VEC = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_req,
    input  logic              nmi_req,
    input  logic              trap_req,
    input  logic              glob_en,
    input  logic              mask_we,
    input  logic [NSRC-1:0]   mask_wdata,
    input  logic              prio_we,
    input  logic [MAP_W-1:0]  prio_wdata,
    input  logic              clr_valid,
    input  logic [CODE_W-1:0] clr_code,
    input  logic              ack,
    input  logic              ret,
    output logic              irq,
    output logic [ID_W-1:0]   irq_code,
    output logic [VEC_W-1:0]  irq_vec,
    output logic              in_service
);
    logic [MAP_W-1:0]             map_q;
    logic [NSRC-1:0][CODE_W-1:0]  lvl;
    logic [NSRC-1:0]              lvl_ok;
    logic [NID-1:0]               pend_q;
    logic [NSRC-1:0]              mask_q;
    logic [NID-1:0]               svc_mask;
    logic [DEPTH_W-1:0]           stk_cnt;
    svc_ent_t                     top_ent;
    id_t                          top_id;
    cand_t                        win;
    logic                         do_push, do_pop, prio_ok, clr_ok;
    logic [NID-1:0]               clr_bits, req_bits;
    svc_ent_t                     push_ent;

    assign req_bits = {trap_req, nmi_req, src_req};
    assign in_service = (stk_cnt != '0);
    assign top_id     = top_ent.id;
    assign prio_ok    = prio_we & ~glob_en & ~in_service;

    intc_prio_map u_map (
        .clk(clk), .rst(rst), .wr_en(prio_ok), .wdata(prio_wdata),
        .map_q(map_q), .lvl_o(lvl), .lvl_ok_o(lvl_ok)
    );

    intc_select u_sel (
        .pend(pend_q), .mask(mask_q), .glob_en(glob_en),
        .lvl(lvl), .lvl_ok(lvl_ok), .win_o(win)
    );

    assign irq     = win.valid && (win.rank < top_ent.rank);
    assign do_pop  = ret && in_service;
    assign do_push = ack && irq && !do_pop;
    assign clr_ok  = clr_valid && !svc_mask[clr_code];

    always_comb begin
        clr_bits = '0;
        if (do_push) clr_bits = clr_bits | id_onehot(win.id);
        if (clr_ok)  clr_bits = clr_bits | id_onehot(id_t'(clr_code));
    end

    intc_pending u_pend (
        .clk(clk), .rst(rst), .set_i(req_bits), .clr_i(clr_bits),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .pend_o(pend_q), .mask_o(mask_q)
    );

    assign push_ent.id   = win.id;
    assign push_ent.rank = win.rank;

    intc_svc_stack u_stk (
        .clk(clk), .rst(rst), .push(do_push), .pop(do_pop), .push_ent(push_ent),
        .top_o(top_ent), .cnt_o(stk_cnt), .svc_mask_o(svc_mask)
    );

    always_comb begin
        irq_code = '0;
        irq_vec  = '0;
        if (irq) begin
            irq_code = win.id;
            if (win.id == id_t'(TRAP_ID))     irq_vec = VEC_W'(TRAP_VEC);
            else if (win.id == id_t'(NMI_ID)) irq_vec = VEC_W'(NMI_VEC);
            else irq_vec = VEC_W'(VEC_BASE + VEC_STEP * int'(win.id));
        end
    end
endmodule

// File: rtl/intc_arbiter_chk.sv
module intc_arbiter_chk
    import intc_pkg::*;
#(
    parameter int VEC_W    = 8,
    parameter int TRAP_VEC = 31
) (
    input logic               clk,
    input logic               rst,
    input logic               irq,
    input logic [ID_W-1:0]    irq_code,
    input logic [VEC_W-1:0]   irq_vec,
    input logic               in_service,
    input logic               ack,
    input logic               ret,
    input logic               glob_en,
    input logic               prio_we,
    input logic               clr_valid,
    input logic [CODE_W-1:0]  clr_code,
    input logic [NID-1:0]     pend,
    input logic [NID-1:0]     svc_mask,
    input logic [ID_W-1:0]    top_id,
    input logic [DEPTH_W-1:0] depth,
    input logic [MAP_W-1:0]   map_q
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq && !in_service));

    // R7
    ack_enters_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && irq && !ret) |=> in_service);

    // R9
    last_return_chk: assert property (@(posedge clk) disable iff (rst)
        (ret && depth == DEPTH_W'(1)) |=> !in_service);

    // R10
    trap_no_nest_chk: assert property (@(posedge clk) disable iff (rst)
        (in_service && top_id == ID_W'(TRAP_ID)) |-> !irq);

    // R5
    trap_vector_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && irq_code == ID_W'(TRAP_ID)) |-> irq_vec == VEC_W'(TRAP_VEC));

    // R6
    disabled_trap_only_chk: assert property (@(posedge clk) disable iff (rst)
        (!glob_en && irq) |-> irq_code == ID_W'(TRAP_ID));

    // R12
    map_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (prio_we && (glob_en || in_service)) |=> $stable(map_q));

    // R11
    clear_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_valid && svc_mask[clr_code] && pend[clr_code]) |=> pend[$past(clr_code)]);
endmodule

bind intc_arbiter intc_arbiter_chk #(.VEC_W(VEC_W), .TRAP_VEC(TRAP_VEC)) u_chk (
    .clk(clk), .rst(rst), .irq(irq), .irq_code(irq_code), .irq_vec(irq_vec),
    .in_service(in_service), .ack(ack), .ret(ret), .glob_en(glob_en),
    .prio_we(prio_we), .clr_valid(clr_valid), .clr_code(clr_code),
    .pend(pend_q), .svc_mask(svc_mask), .top_id(top_id), .depth(stk_cnt),
    .map_q(map_q)
);

// File: tb/sim_intc_arbiter.sv
`timescale 1ns/1ps
module sim_intc_arbiter;
    import intc_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst = 1'b1;
    logic [NSRC-1:0]   src_req = '0;
    logic              nmi_req = 1'b0, trap_req = 1'b0, glob_en = 1'b0;
    logic              mask_we = 1'b0, prio_we = 1'b0, clr_valid = 1'b0;
    logic              ack = 1'b0, ret = 1'b0;
    logic [NSRC-1:0]   mask_wdata = '0;
    logic [MAP_W-1:0]  prio_wdata = '0;
    logic [CODE_W-1:0] clr_code = '0;
    logic              irq, in_service;
    logic [ID_W-1:0]   irq_code;
    logic [7:0]        irq_vec;

    intc_arbiter u0 (
        .clk(clk), .rst(rst), .src_req(src_req), .nmi_req(nmi_req), .trap_req(trap_req),
        .glob_en(glob_en), .mask_we(mask_we), .mask_wdata(mask_wdata),
        .prio_we(prio_we), .prio_wdata(prio_wdata), .clr_valid(clr_valid),
        .clr_code(clr_code), .ack(ack), .ret(ret), .irq(irq), .irq_code(irq_code),
        .irq_vec(irq_vec), .in_service(in_service)
    );

    int    n_chk = 0, n_err = 0;
    string tag = "R1";
    bit    done = 1'b0;

    // Behavioural reference model
    bit       m_pend [10];
    bit [7:0] m_mask;
    int       m_map [8];
    int       m_stk [$];

    function automatic int m_lvl(int c);
        for (int s = 0; s < 8; s++) if (m_map[s] == c) return s;
        return -1;
    endfunction

    function automatic int m_rank(int id);
        if (id == 9) return 0;
        if (id == 8) return 1;
        return m_lvl(id) + 2;
    endfunction

    function automatic bit m_busy(int c);
        foreach (m_stk[i]) if (m_stk[i] == c) return 1'b1;
        return 1'b0;
    endfunction

    function automatic void m_out(output int e_irq, output int e_id);
        int rk, cur;
        e_id = -1; rk = 10;
        for (int c = 0; c < 8; c++) begin
            if (m_pend[c] && m_mask[c] && glob_en && m_lvl(c) >= 0 && m_lvl(c) + 2 < rk) begin
                e_id = c; rk = m_lvl(c) + 2;
            end
        end
        if (m_pend[8] && glob_en) begin e_id = 8; rk = 1; end
        if (m_pend[9]) begin e_id = 9; rk = 0; end
        cur = (m_stk.size() == 0) ? 10 : m_rank(m_stk[$]);
        e_irq = (e_id >= 0 && rk < cur) ? 1 : 0;
    endfunction

    function automatic int m_vec(int id);
        if (id == 9) return 31;
        if (id == 8) return 29;
        return 3 + 2 * id;
    endfunction

    task automatic m_update();
        int e_irq, e_id;
        bit clr_ok, prio_ok;
        if (rst) begin
            foreach (m_pend[i]) m_pend[i] = 1'b0;
            m_mask = '0;
            for (int s = 0; s < 8; s++) m_map[s] = s;
            m_stk.delete();
            return;
        end
        m_out(e_irq, e_id);
        clr_ok  = clr_valid && !m_busy(int'(clr_code));
        prio_ok = prio_we && !glob_en && m_stk.size() == 0;
        if (ret && m_stk.size() > 0) void'(m_stk.pop_back());
        else if (ack && e_irq == 1) begin
            m_pend[e_id] = 1'b0;
            m_stk.push_back(e_id);
        end
        if (clr_ok) m_pend[int'(clr_code)] = 1'b0;
        for (int c = 0; c < 8; c++) if (src_req[c]) m_pend[c] = 1'b1;
        if (nmi_req)  m_pend[8] = 1'b1;
        if (trap_req) m_pend[9] = 1'b1;
        if (mask_we) m_mask = mask_wdata;
        if (prio_ok) for (int s = 0; s < 8; s++) m_map[s] = int'(prio_wdata[s*3 +: 3]);
    endtask

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic compare();
        int e_irq, e_id;
        m_out(e_irq, e_id);
        check(tag, "irq", int'(irq), e_irq);
        check(tag, "irq_code", int'(irq_code), e_irq ? e_id : 0);
        check(tag, "irq_vec", int'(irq_vec), e_irq ? m_vec(e_id) : 0);
        check(tag, "in_service", int'(in_service), m_stk.size() > 0 ? 1 : 0);
    endtask

    task automatic tick();
        @(posedge clk);
        m_update();
        @(negedge clk);
        compare();
        src_req = '0; nmi_req = 1'b0; trap_req = 1'b0;
        mask_we = 1'b0; prio_we = 1'b0; clr_valid = 1'b0; ack = 1'b0; ret = 1'b0;
    endtask

    task automatic pulse(logic [7:0] b); src_req = b; tick(); endtask
    task automatic take();   ack = 1'b1; tick(); endtask
    task automatic leave();  ret = 1'b1; tick(); endtask
    task automatic wmask(logic [7:0] v); mask_we = 1'b1; mask_wdata = v; tick(); endtask
    task automatic wmap(logic [23:0] v); prio_we = 1'b1; prio_wdata = v; tick(); endtask
    task automatic clr(int c); clr_valid = 1'b1; clr_code = CODE_W'(c); tick(); endtask

    localparam logic [23:0] MAP_DEF = {3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0};
    localparam logic [23:0] MAP_REV = {3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
    localparam logic [23:0] MAP_DUP = {3'd4, 3'd4, 3'd4, 3'd4, 3'd2, 3'd4, 3'd4, 3'd4};

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        tag = "R1";
        @(negedge clk);
        tick(); tick();
        rst = 1'b0;
        tick();
        check("R1", "irq after reset", int'(irq), 0);
        check("R1", "in_service after reset", int'(in_service), 0);

        // R2 masked request held, served once unmasked
        tag = "R2"; glob_en = 1'b1;
        pulse(8'h08); tick(); tick();
        check("R2", "masked irq", int'(irq), 0);
        wmask(8'hFF);
        check("R2", "unmasked code", int'(irq_code), 3);
        tag = "R13";
        check("R13", "vector code 3", int'(irq_vec), 9);
        // R7 acknowledge
        tag = "R7";
        take();
        check("R7", "in_service after ack", int'(in_service), 1);
        leave();

        // R3 slot ordering, default and reversed map
        tag = "R3";
        pulse(8'h64);
        check("R3", "default map winner", int'(irq_code), 2);
        take(); leave(); take(); leave(); take(); leave();
        glob_en = 1'b0; wmap(MAP_REV); glob_en = 1'b1;
        pulse(8'h42);
        check("R3", "reversed map winner", int'(irq_code), 6);
        take(); leave(); take(); leave();

        // R4 duplicates and missing code
        tag = "R4";
        glob_en = 1'b0; wmap(MAP_DUP); glob_en = 1'b1;
        pulse(8'h16);
        check("R4", "duplicate winner", int'(irq_code), 4);
        take(); leave();
        take(); leave();
        tick();
        check("R4", "absent code not presented", int'(irq), 0);
        clr(1);
        glob_en = 1'b0; wmap(MAP_DEF); glob_en = 1'b1;
        tick();

        // R5 trap > nmi > sources; R10 trap handler not nested
        tag = "R5";
        src_req = 8'h01; nmi_req = 1'b1; trap_req = 1'b1; tick();
        check("R5", "trap first", int'(irq_code), 9);
        tag = "R10";
        take(); tick();
        check("R10", "no nesting in trap", int'(irq), 0);
        leave();
        tag = "R5";
        check("R5", "nmi next", int'(irq_code), 8);
        check("R13", "nmi vector", int'(irq_vec), 29);
        take(); leave(); take(); leave();
        wmask(8'h00); nmi_req = 1'b1; tick();
        check("R5", "nmi ignores mask", int'(irq_code), 8);
        take(); leave();
        wmask(8'hFF);

        // R6 global disable
        tag = "R6";
        glob_en = 1'b0;
        src_req = 8'h02; nmi_req = 1'b1; tick();
        check("R6", "disabled quiet", int'(irq), 0);
        trap_req = 1'b1; tick();
        check("R6", "trap while disabled", int'(irq_code), 9);
        take(); leave();
        glob_en = 1'b1; tick();
        take(); leave(); take(); leave();

        // R8 nesting, R9 restore
        tag = "R8";
        pulse(8'h20); take();
        pulse(8'h40);
        check("R8", "lower does not preempt", int'(irq), 0);
        pulse(8'h20);
        check("R8", "equal does not preempt", int'(irq), 0);
        pulse(8'h04);
        check("R8", "higher preempts", int'(irq_code), 2);
        take();
        tag = "R9";
        leave();
        check("R9", "restored level blocks 5 and 6", int'(irq), 0);
        leave();
        check("R9", "idle after returns", int'(in_service), 0);
        take(); leave(); take(); leave();

        // R11 clear
        tag = "R11";
        wmask(8'hEF); pulse(8'h10); clr(4); wmask(8'hFF); tick();
        check("R11", "cleared request gone", int'(irq), 0);
        pulse(8'h10); take(); pulse(8'h10); clr(4); leave();
        check("R11", "clear ignored in service", int'(irq_code), 4);
        take(); leave();

        // R12 map writes blocked
        tag = "R12";
        wmap(MAP_REV);
        pulse(8'h81);
        check("R12", "map unchanged while enabled", int'(irq_code), 0);
        take(); glob_en = 1'b0; wmap(MAP_REV); glob_en = 1'b1; leave();
        check("R12", "map unchanged in service", int'(irq_code), 7);
        take(); leave();

        // R14 request beats clear and ack
        tag = "R14";
        src_req = 8'h80; clr_valid = 1'b1; clr_code = 3'd7; tick();
        check("R14", "request beats clear", int'(irq_code), 7);
        src_req = 8'h80; ack = 1'b1; tick();
        leave();
        check("R14", "request beats ack", int'(irq_code), 7);
        take(); leave();
        tick();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule